// File: doc/BRIEF.md
# Decoder Data Reordering Endianness Manager

This block sits between a 64-bit DMA bus and a turbo-decoder kernel and puts each kind of decoder data into the lane order that the other side expects. Interleaver index beats flow from DMA to kernel, with their 16-bit lanes permuted. Extrinsic beats flow in both directions, with their byte lanes permuted. Channel-symbol beats flow inbound and have their reserved bits cleared. Hard-decision bits leave the kernel one per transfer and are packed into 64-bit beats for the DMA, in a bit direction that can be selected.

Each stream uses a valid/ready handshake and a frame-end flag. The three reorder streams are combinational: a beat passes straight through, and back-pressure passes straight back. The hard-decision packer is registered and holds a complete beat until it is taken. Each stream samples its mode input on the first beat of a frame and keeps that value until the frame's last beat has been accepted.

Top module: `decoder_reorder_unit`

## Requirements
- R1: After reset, hd_out_valid is 0 and hd_in_ready is 1.
- R2: With cfg_idx_native=1 the DMA index beat carries index 0 in bits 63:48, index 1 in bits 47:32, index 2 in bits 31:16 and index 3 in bits 15:0. The kernel beat carries index j in bits 16j+15:16j.
- R3: With cfg_idx_native=0 the DMA index beat carries, from the top halfword down, index 1, index 0, index 3 and index 2. The kernel layout is the same as in R2.
- R4: Each kernel index lane holds a 15-bit index in its low 15 bits, and its bit 15 is always 0, whatever the DMA lane held there.
- R5: On the kernel side, extrinsic k occupies bits 8k+7:8k. With cfg_ext_native=0, DMA byte lanes 0 to 7 (lane k is bits 8k+7:8k) carry extrinsics 3,2,1,0,7,6,5,4, and the inbound path converts this to the kernel layout.
- R6: With cfg_ext_native=1 both extrinsic paths pass the beat through unchanged.
- R7: The outbound extrinsic path converts a kernel-layout beat to the DMA layout of R5 (or R6), so that it is the exact inverse of the inbound path.
- R8: Symbol beats pass bits 29:0 and 61:32 through unchanged, and bits 31:30 and 63:62 are output as 0.
- R9: With cfg_hd_msb_first=0, the k-th hard decision of a beat (k=0..63, counted from the start of the frame modulo 64) is placed at bit k.
- R10: With cfg_hd_msb_first=1, the k-th hard decision is placed at bit 32*(k/32) + 31 - (k mod 32), so that each 32-bit half is filled from its top bit downwards.
- R11: A beat is emitted after 64 decisions or on the decision flagged last, whichever comes first. hd_out_last follows the last flag, and bit positions that were not filled are 0.
- R12: Every stream samples its mode input on the first beat of a frame and keeps using it until a beat flagged last is accepted. Changes in between have no effect.
- R13: While hd_out_valid is 1 and hd_out_ready is 0, hd_out_data and hd_out_last hold and hd_in_ready is 0.
- R14: On the reorder streams the output valid follows the input valid, the input ready follows the output ready, and the last flag passes through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_idx_native | input | 1 | Index lane order select |
| cfg_ext_native | input | 1 | Extrinsic byte order select |
| cfg_hd_msb_first | input | 1 | Hard-decision bit direction select |
| idx_in_valid | input | 1 | DMA index beat valid |
| idx_in_ready | output | 1 | DMA index beat ready |
| idx_in_data | input | 64 | DMA index beat |
| idx_in_last | input | 1 | DMA index frame end |
| idx_out_valid | output | 1 | Kernel index beat valid |
| idx_out_ready | input | 1 | Kernel index beat ready |
| idx_out_data | output | 64 | Kernel index beat |
| idx_out_last | output | 1 | Kernel index frame end |
| exti_in_valid | input | 1 | DMA extrinsic beat valid |
| exti_in_ready | output | 1 | DMA extrinsic beat ready |
| exti_in_data | input | 64 | DMA extrinsic beat |
| exti_in_last | input | 1 | DMA extrinsic frame end |
| exti_out_valid | output | 1 | Kernel extrinsic beat valid |
| exti_out_ready | input | 1 | Kernel extrinsic beat ready |
| exti_out_data | output | 64 | Kernel extrinsic beat |
| exti_out_last | output | 1 | Kernel extrinsic frame end |
| exto_in_valid | input | 1 | Kernel extrinsic beat valid |
| exto_in_ready | output | 1 | Kernel extrinsic beat ready |
| exto_in_data | input | 64 | Kernel extrinsic beat |
| exto_in_last | input | 1 | Kernel extrinsic frame end |
| exto_out_valid | output | 1 | DMA extrinsic beat valid |
| exto_out_ready | input | 1 | DMA extrinsic beat ready |
| exto_out_data | output | 64 | DMA extrinsic beat |
| exto_out_last | output | 1 | DMA extrinsic frame end |
| sym_in_valid | input | 1 | DMA symbol beat valid |
| sym_in_ready | output | 1 | DMA symbol beat ready |
| sym_in_data | input | 64 | DMA symbol beat |
| sym_in_last | input | 1 | DMA symbol frame end |
| sym_out_valid | output | 1 | Kernel symbol beat valid |
| sym_out_ready | input | 1 | Kernel symbol beat ready |
| sym_out_data | output | 64 | Kernel symbol beat |
| sym_out_last | output | 1 | Kernel symbol frame end |
| hd_in_valid | input | 1 | Hard decision valid |
| hd_in_ready | output | 1 | Hard decision ready |
| hd_in_bit | input | 1 | Hard decision value |
| hd_in_last | input | 1 | Last decision of the frame |
| hd_out_valid | output | 1 | Packed beat valid |
| hd_out_ready | input | 1 | Packed beat ready |
| hd_out_data | output | 64 | Packed beat |
| hd_out_last | output | 1 | Packed beat ends the frame |

## Verification
The reorder-stream assertions take for granted that a source keeps its data and last flag steady while valid is high. Only then is the mode-hold and round-trip reasoning tied to one beat, and the bench changes a beat only after the edge that accepts it. The mode-hold properties expect mode inputs to be able to move at any time. For that reason the stimulus flips them deliberately in the middle of index, extrinsic and hard-decision frames. The packer properties expect the kernel to emit one decision per accepted transfer. The stimulus holds the output ready low across a full beat to exercise the stall.

// File: rtl/edm_pkg.sv
package edm_pkg;
  parameter int BEAT_W        = 64;
  parameter int IDX_W         = 16;
  parameter int IDX_N         = BEAT_W / IDX_W;
  parameter int EXT_W         = 8;
  parameter int EXT_N         = BEAT_W / EXT_W;
  parameter int WORD_W        = 32;
  parameter int HALF_N        = BEAT_W / WORD_W;
  parameter int EXT_PER_WORD  = WORD_W / EXT_W;
  parameter int SOFT_W        = 6;
  parameter int SOFT_PER_WORD = 5;
  parameter int PAY_W         = SOFT_W * SOFT_PER_WORD;
  parameter int CNT_W         = $clog2(BEAT_W);

  typedef enum logic [0:0] {PATH_INDEX, PATH_EXTR} path_kind_e;

  // DMA index lanes to kernel order; native swaps all lanes, packed swaps pairs.
  function automatic logic [BEAT_W-1:0] index_to_kernel(input logic [BEAT_W-1:0] d,
                                                        input logic native);
    logic [BEAT_W-1:0] r;
    int src;
    r = '0;
    for (int j = 0; j < IDX_N; j++) begin
      src = native ? (j ^ (IDX_N - 1)) : (j ^ (IDX_N / 2));
      r[j*IDX_W +: IDX_W-1] = d[src*IDX_W +: IDX_W-1];
    end
    return r;
  endfunction

  // Byte reversal inside each 32-bit word unless native; it is its own inverse.
  function automatic logic [BEAT_W-1:0] ext_swap(input logic [BEAT_W-1:0] d,
                                                 input logic native);
    logic [BEAT_W-1:0] r;
    int src;
    r = '0;
    for (int k = 0; k < EXT_N; k++) begin
      src = native ? k : (k ^ (EXT_PER_WORD - 1));
      r[k*EXT_W +: EXT_W] = d[src*EXT_W +: EXT_W];
    end
    return r;
  endfunction

  // Keep the soft-value payload of each word, zero its spare top bits.
  function automatic logic [BEAT_W-1:0] symbol_clean(input logic [BEAT_W-1:0] d);
    logic [BEAT_W-1:0] r;
    r = '0;
    for (int h = 0; h < HALF_N; h++) begin
      r[h*WORD_W +: PAY_W] = d[h*WORD_W +: PAY_W];
    end
    return r;
  endfunction

  // Bit slot of the k-th decision in a beat.
  function automatic logic [CNT_W-1:0] hd_bit_pos(input logic [CNT_W-1:0] k,
                                                  input logic msb_first);
    return msb_first ? (k ^ CNT_W'(WORD_W - 1)) : k;
  endfunction
endpackage

// File: rtl/edm_mode_hold.sv
module edm_mode_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_live,
  input  logic fire,
  input  logic last,
  output logic mode_eff
);
  logic in_frame;
  logic held;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      held     <= 1'b0;
    end else if (fire) begin
      if (!in_frame) held <= mode_live;
      in_frame <= !last;
    end
  end

  assign mode_eff = in_frame ? held : mode_live;

  // R12: the mode used for a beat carries on to the next beat of the frame
  assert_mode_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !last) |=> (mode_eff == $past(mode_eff)));
endmodule

// File: rtl/edm_lane_path.sv
module edm_lane_path
  import edm_pkg::*;
#(
  parameter path_kind_e KIND = PATH_INDEX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_live,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [BEAT_W-1:0] s_data,
  input  logic              s_last,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [BEAT_W-1:0] m_data,
  output logic              m_last
);
  logic fire;
  logic mode_eff;

  assign fire    = s_valid && s_ready;
  assign s_ready = m_ready;
  assign m_valid = s_valid;
  assign m_last  = s_last;

  edm_mode_hold u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_live(mode_live),
    .fire     (fire),
    .last     (s_last),
    .mode_eff (mode_eff)
  );

  generate
    if (KIND == PATH_INDEX) begin : g_index
      assign m_data = index_to_kernel(s_data, mode_eff);
    end else begin : g_extr
      assign m_data = ext_swap(s_data, mode_eff);
      // R7: applying the permutation again restores the source beat
      assert_ext_roundtrip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_valid |-> (ext_swap(m_data, mode_eff) == s_data));
    end
  endgenerate
endmodule

// File: rtl/edm_hd_packer.sv
module edm_hd_packer
  import edm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_live,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic              s_bit,
  input  logic              s_last,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [BEAT_W-1:0] m_data,
  output logic              m_last
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(BEAT_W - 1);

  logic [BEAT_W-1:0] acc;
  logic [BEAT_W-1:0] acc_next;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  pos;
  logic              fire;
  logic              beat_done;
  logic              mode_eff;

  assign s_ready   = !m_valid;
  assign fire      = s_valid && s_ready;
  assign beat_done = s_last || (cnt == CNT_MAX);
  assign pos       = hd_bit_pos(cnt, mode_eff);
  assign acc_next  = acc | (BEAT_W'(s_bit) << pos);

  edm_mode_hold u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_live(mode_live),
    .fire     (fire),
    .last     (s_last),
    .mode_eff (mode_eff)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc     <= '0;
      cnt     <= '0;
      m_valid <= 1'b0;
      m_data  <= '0;
      m_last  <= 1'b0;
    end else begin
      if (m_valid && m_ready) m_valid <= 1'b0;
      if (fire) begin
        if (beat_done) begin
          m_data  <= acc_next;
          m_last  <= s_last;
          m_valid <= 1'b1;
          acc     <= '0;
          cnt     <= '0;
        end else begin
          acc <= acc_next;
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R13: a stalled beat is held
  assert_hold_stable_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));
  // R11: the frame's final decision always produces a flagged beat
  assert_flush_on_last_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && s_last) |=> (m_valid && m_last));
  // R9: no beat appears before 64 decisions unless the frame ends
  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !s_last && cnt != CNT_MAX) |=> !m_valid);
endmodule

// File: rtl/decoder_reorder_unit.sv
module decoder_reorder_unit
  import edm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_idx_native,
  input  logic              cfg_ext_native,
  input  logic              cfg_hd_msb_first,
  input  logic              idx_in_valid,
  output logic              idx_in_ready,
  input  logic [BEAT_W-1:0] idx_in_data,
  input  logic              idx_in_last,
  output logic              idx_out_valid,
  input  logic              idx_out_ready,
  output logic [BEAT_W-1:0] idx_out_data,
  output logic              idx_out_last,
  input  logic              exti_in_valid,
  output logic              exti_in_ready,
  input  logic [BEAT_W-1:0] exti_in_data,
  input  logic              exti_in_last,
  output logic              exti_out_valid,
  input  logic              exti_out_ready,
  output logic [BEAT_W-1:0] exti_out_data,
  output logic              exti_out_last,
  input  logic              exto_in_valid,
  output logic              exto_in_ready,
  input  logic [BEAT_W-1:0] exto_in_data,
  input  logic              exto_in_last,
  output logic              exto_out_valid,
  input  logic              exto_out_ready,
  output logic [BEAT_W-1:0] exto_out_data,
  output logic              exto_out_last,
  input  logic              sym_in_valid,
  output logic              sym_in_ready,
  input  logic [BEAT_W-1:0] sym_in_data,
  input  logic              sym_in_last,
  output logic              sym_out_valid,
  input  logic              sym_out_ready,
  output logic [BEAT_W-1:0] sym_out_data,
  output logic              sym_out_last,
  input  logic              hd_in_valid,
  output logic              hd_in_ready,
  input  logic              hd_in_bit,
  input  logic              hd_in_last,
  output logic              hd_out_valid,
  input  logic              hd_out_ready,
  output logic [BEAT_W-1:0] hd_out_data,
  output logic              hd_out_last
);
  edm_lane_path #(.KIND(PATH_INDEX)) u_idx (
    .clk(clk), .rst_n(rst_n), .mode_live(cfg_idx_native),
    .s_valid(idx_in_valid), .s_ready(idx_in_ready), .s_data(idx_in_data), .s_last(idx_in_last),
    .m_valid(idx_out_valid), .m_ready(idx_out_ready), .m_data(idx_out_data), .m_last(idx_out_last)
  );

  edm_lane_path #(.KIND(PATH_EXTR)) u_ext_in (
    .clk(clk), .rst_n(rst_n), .mode_live(cfg_ext_native),
    .s_valid(exti_in_valid), .s_ready(exti_in_ready), .s_data(exti_in_data), .s_last(exti_in_last),
    .m_valid(exti_out_valid), .m_ready(exti_out_ready), .m_data(exti_out_data), .m_last(exti_out_last)
  );

  edm_lane_path #(.KIND(PATH_EXTR)) u_ext_out (
    .clk(clk), .rst_n(rst_n), .mode_live(cfg_ext_native),
    .s_valid(exto_in_valid), .s_ready(exto_in_ready), .s_data(exto_in_data), .s_last(exto_in_last),
    .m_valid(exto_out_valid), .m_ready(exto_out_ready), .m_data(exto_out_data), .m_last(exto_out_last)
  );

  assign sym_out_valid = sym_in_valid;
  assign sym_in_ready  = sym_out_ready;
  assign sym_out_last  = sym_in_last;
  assign sym_out_data  = symbol_clean(sym_in_data);

  edm_hd_packer u_hd (
    .clk(clk), .rst_n(rst_n), .mode_live(cfg_hd_msb_first),
    .s_valid(hd_in_valid), .s_ready(hd_in_ready), .s_bit(hd_in_bit), .s_last(hd_in_last),
    .m_valid(hd_out_valid), .m_ready(hd_out_ready), .m_data(hd_out_data), .m_last(hd_out_last)
  );
endmodule

// File: tb/decoder_reorder_unit_tb.sv
`timescale 1ns/1ps
module decoder_reorder_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_idx_native = 1'b0, cfg_ext_native = 1'b0, cfg_hd_msb_first = 1'b0;
  logic idx_in_valid = 0, idx_in_last = 0, idx_out_ready = 1;
  logic exti_in_valid = 0, exti_in_last = 0, exti_out_ready = 1;
  logic exto_in_valid = 0, exto_in_last = 0, exto_out_ready = 1;
  logic sym_in_valid = 0, sym_in_last = 0, sym_out_ready = 1;
  logic hd_in_valid = 0, hd_in_bit = 0, hd_in_last = 0, hd_out_ready = 1;
  logic [63:0] idx_in_data = '0, exti_in_data = '0, exto_in_data = '0, sym_in_data = '0;
  logic idx_in_ready, idx_out_valid, idx_out_last;
  logic exti_in_ready, exti_out_valid, exti_out_last;
  logic exto_in_ready, exto_out_valid, exto_out_last;
  logic sym_in_ready, sym_out_valid, sym_out_last;
  logic hd_in_ready, hd_out_valid, hd_out_last;
  logic [63:0] idx_out_data, exti_out_data, exto_out_data, sym_out_data, hd_out_data;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;
  logic [15:0] lfsr = 16'hACE1;

  logic [64:0] q_idx[$], q_exti[$], q_exto[$], q_sym[$], q_hd[$];
  string t_idx[$], t_exti[$], t_exto[$], t_sym[$], t_hd[$];

  always #10 clk = ~clk;

  decoder_reorder_unit u_dut (.*);

  task automatic check(string tag, logic [64:0] act, logic [64:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic miss(string tag);
    nchk++; nfail++;
    $display("FAIL %s actual=unexpected_beat expected=none", tag);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (idx_out_valid && idx_out_ready) begin
      if (q_idx.size() == 0) miss("R14 idx");
      else check(t_idx.pop_front(), {idx_out_last, idx_out_data}, q_idx.pop_front());
    end
    if (exti_out_valid && exti_out_ready) begin
      if (q_exti.size() == 0) miss("R14 exti");
      else check(t_exti.pop_front(), {exti_out_last, exti_out_data}, q_exti.pop_front());
    end
    if (exto_out_valid && exto_out_ready) begin
      if (q_exto.size() == 0) miss("R14 exto");
      else check(t_exto.pop_front(), {exto_out_last, exto_out_data}, q_exto.pop_front());
    end
    if (sym_out_valid && sym_out_ready) begin
      if (q_sym.size() == 0) miss("R14 sym");
      else check(t_sym.pop_front(), {sym_out_last, sym_out_data}, q_sym.pop_front());
    end
    if (hd_out_valid && hd_out_ready) begin
      if (q_hd.size() == 0) miss("R11 hd");
      else check(t_hd.pop_front(), {hd_out_last, hd_out_data}, q_hd.pop_front());
    end
  end

  task automatic drv_idx(logic [63:0] d, logic l);
    idx_in_data = d; idx_in_last = l; idx_in_valid = 1;
    @(negedge clk); while (!idx_in_ready) @(negedge clk);
    @(posedge clk); #1 idx_in_valid = 0;
  endtask
  task automatic drv_exti(logic [63:0] d, logic l);
    exti_in_data = d; exti_in_last = l; exti_in_valid = 1;
    @(negedge clk); while (!exti_in_ready) @(negedge clk);
    @(posedge clk); #1 exti_in_valid = 0;
  endtask
  task automatic drv_exto(logic [63:0] d, logic l);
    exto_in_data = d; exto_in_last = l; exto_in_valid = 1;
    @(negedge clk); while (!exto_in_ready) @(negedge clk);
    @(posedge clk); #1 exto_in_valid = 0;
  endtask
  task automatic drv_sym(logic [63:0] d, logic l);
    sym_in_data = d; sym_in_last = l; sym_in_valid = 1;
    @(negedge clk); while (!sym_in_ready) @(negedge clk);
    @(posedge clk); #1 sym_in_valid = 0;
  endtask
  task automatic drv_hd(logic b, logic l);
    hd_in_bit = b; hd_in_last = l; hd_in_valid = 1;
    @(negedge clk); while (!hd_in_ready) @(negedge clk);
    @(posedge clk); #1 hd_in_valid = 0;
  endtask

  function automatic logic [31:0] rev32(logic [31:0] w);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = w[31-i];
    return r;
  endfunction

  // hard-decision frame: expected beats built from the requirement text
  task automatic hd_frame(int n, bit order, bit flip_mid, string tag);
    logic [63:0] plain = '0;
    cfg_hd_msb_first = order;
    for (int k = 0; k < n; k++) begin
      logic b;
      b = lfsr[0];
      lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
      plain[k % 64] = b;
      if ((k % 64) == 63 || k == n - 1) begin
        q_hd.push_back({(k == n - 1), order ? {rev32(plain[63:32]), rev32(plain[31:0])} : plain});
        t_hd.push_back(tag);
        plain = '0;
      end
      if (flip_mid && k == 1) cfg_hd_msb_first = !order;
      drv_hd(b, k == n - 1);
    end
  endtask

  function automatic logic [63:0] kern_idx(logic [15:0] i0, i1, i2, i3);
    return {1'b0, i3[14:0], 1'b0, i2[14:0], 1'b0, i1[14:0], 1'b0, i0[14:0]};
  endfunction

  initial begin
    logic [15:0] i0, i1, i2, i3;
    logic [7:0] e[8];
    logic [63:0] kern, dma0, snap;
    repeat (3) @(negedge clk);
    check("R1 reset", {63'd0, hd_out_valid, hd_in_ready}, 65'b01);
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    check("R1 after reset", {63'd0, hd_out_valid, hd_in_ready}, 65'b01);
    @(posedge clk); #1;

    // index paths (R2, R3, R4, R12)
    i0 = 16'h8123; i1 = 16'h0456; i2 = 16'hF789; i3 = 16'h7ABC;
    cfg_idx_native = 1;
    q_idx.push_back({1'b1, kern_idx(i0, i1, i2, i3)}); t_idx.push_back("R2 R4 idx native");
    drv_idx({i0, i1, i2, i3}, 1);
    cfg_idx_native = 0;
    q_idx.push_back({1'b1, kern_idx(i0, i1, i2, i3)}); t_idx.push_back("R3 R4 idx packed");
    drv_idx({i1, i0, i3, i2}, 1);
    cfg_idx_native = 1;
    q_idx.push_back({1'b0, kern_idx(i3, i2, i1, i0)}); t_idx.push_back("R12 idx first beat");
    drv_idx({i3, i2, i1, i0}, 0);
    cfg_idx_native = 0;
    q_idx.push_back({1'b1, kern_idx(i1, i0, i3, i2)}); t_idx.push_back("R12 idx held mode");
    drv_idx({i1, i0, i3, i2}, 1);
    q_idx.push_back({1'b1, kern_idx(i3, i1, i0, i2)}); t_idx.push_back("R12 idx new frame");
    drv_idx({i1, i3, i2, i0}, 1);

    // R14 back-pressure passes straight through
    idx_out_ready = 0; idx_in_data = 64'h1; idx_in_last = 1; idx_in_valid = 1;
    @(negedge clk);
    check("R14 idx ready/valid", {63'd0, idx_in_ready, idx_out_valid}, 65'b01);
    @(posedge clk); #1 idx_in_valid = 0; idx_out_ready = 1;

    // extrinsic paths (R5, R6, R7, R12)
    for (int k = 0; k < 8; k++) e[k] = 8'h10 * k[7:0] + 8'h0F - k[7:0];
    kern = {e[7], e[6], e[5], e[4], e[3], e[2], e[1], e[0]};
    dma0 = {e[4], e[5], e[6], e[7], e[0], e[1], e[2], e[3]};
    cfg_ext_native = 0;
    q_exti.push_back({1'b1, kern}); t_exti.push_back("R5 ext in word order");
    drv_exti(dma0, 1);
    q_exto.push_back({1'b1, dma0}); t_exto.push_back("R7 ext out word order");
    drv_exto(kern, 1);
    cfg_ext_native = 1;
    q_exti.push_back({1'b1, dma0}); t_exti.push_back("R6 ext in native");
    drv_exti(dma0, 1);
    q_exto.push_back({1'b1, kern}); t_exto.push_back("R6 ext out native");
    drv_exto(kern, 1);
    cfg_ext_native = 0;
    q_exti.push_back({1'b0, kern}); t_exti.push_back("R12 ext first beat");
    drv_exti(dma0, 0);
    cfg_ext_native = 1;
    q_exti.push_back({1'b1, kern}); t_exti.push_back("R12 ext held mode");
    drv_exti(dma0, 1);

    // symbols (R8)
    q_sym.push_back({1'b1, 64'h3FFF_FFFF_3FFF_FFFF}); t_sym.push_back("R8 sym all ones");
    drv_sym(64'hFFFF_FFFF_FFFF_FFFF, 1);
    q_sym.push_back({1'b0, 64'h0234_5678_1BCD_EF01}); t_sym.push_back("R8 sym mixed");
    drv_sym(64'hC234_5678_DBCD_EF01, 0);

    // hard decisions (R9, R10, R11, R12)
    hd_frame(64, 0, 0, "R9 hd full beat lsb-first");
    hd_frame(100, 1, 0, "R10 R11 hd msb-first with partial");
    hd_frame(20, 0, 1, "R12 R11 hd mode held partial");
    hd_frame(1, 1, 0, "R10 R11 hd single decision");

    // stall (R13)
    @(posedge clk); #1 hd_out_ready = 0;
    fork
      hd_frame(128, 1, 0, "R13 hd after stall");
      begin
        repeat (70) @(posedge clk);
        @(negedge clk);
        check("R13 stalled valid/ready", {63'd0, hd_out_valid, hd_in_ready}, 65'b10);
        snap = hd_out_data;
        repeat (3) @(negedge clk);
        check("R13 stalled data held", {1'b0, hd_out_data}, {1'b0, snap});
        @(posedge clk); #1 hd_out_ready = 1;
      end
    join
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R14 all idx beats seen", 65'(q_idx.size()), 65'd0);
    check("R7 all ext beats seen", 65'(q_exti.size() + q_exto.size()), 65'd0);
    check("R8 all sym beats seen", 65'(q_sym.size()), 65'd0);
    check("R11 all hd beats seen", 65'(q_hd.size()), 65'd0);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule